// File: doc/BRIEF.md
# Cascadable Serial Result Port

This block is the readout side of a sampling converter. It keeps the latest conversion word in a shift register and sends it out MSB first, one bit for each rising edge of an external shift clock. The word is loaded on the falling edge of the converter's busy flag, so the top bit is on the data output before the host gives its first clock. Readout is not tied to the converter, so it can also happen while the converter is idle between conversions.

A strap input selects one of two modes, and one dual-use input pin changes meaning with that strap. In shared-line mode the pin is an active-low output enable, so several ports can take turns on one data wire. In cascade mode the output is always driven and the pin becomes the serial input from the upstream port. Bits from upstream enter at the LSB end, so this port's own word leaves first and the upstream word follows it. The external shift clock and the dual pin pass through the same synchronizer into the system clock domain, and a rising-edge detector turns the shift clock into one-cycle shift strobes. The block drives a data output and a separate output-enable signal instead of a bidirectional pad.

Top module: `chain_sport`

## Requirements
- R1: In shared-line mode (`chain_i` = 0), `sdo_oe_o` follows the inverse of `dual_i`: a 1 on `dual_i` releases the line and a 0 drives it. The change shows within SYNC_STAGES+1 system clock cycles.
- R2: In cascade mode (`chain_i` = 1), `sdo_oe_o` is 1 whatever the level on `dual_i`.
- R3: Each rising edge of `sclk_i` moves the word one place toward the MSB, and `sdo_o` then shows the next lower bit. Falling edges of `sclk_i` leave `sdo_o` unchanged.
- R4: A 1-to-0 step of `busy_i` loads `result_i` into the shift register, and bit DATA_W-1 appears on `sdo_o` in the next cycle. While `busy_i` does not fall, changes on `result_i` have no effect on `sdo_o`.
- R5: In cascade mode, each rising shift edge takes the level on `dual_i` into bit 0. The first upstream bit reaches `sdo_o` on the DATA_W-th rising edge after the load.
- R6: In shared-line mode, the bits shifted in at the LSB are 0, so after DATA_W rising edges `sdo_o` stays 0.
- R7: If a load and a shift strobe fall in the same system clock cycle, the load takes priority (LOAD_WINS = 1): `sdo_o` shows bit DATA_W-1 of the new word and that shift edge is dropped.
- R8: While `rst_n` is 0, the shift register clears, `sdo_o` is 0 and `sdo_oe_o` is 0.
- R9: The shift strobe is a single-cycle pulse for each rising edge of `sclk_i`, and a shift shows on `sdo_o` within SYNC_STAGES+2 system clock cycles of that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Converter busy flag, synchronous to clk; its falling edge loads the word |
| result_i | input | DATA_W | Conversion word from the converter |
| chain_i | input | 1 | Mode strap: 0 shared-line, 1 cascade |
| dual_i | input | 1 | Active-low output enable (shared-line) or upstream serial data (cascade) |
| sclk_i | input | 1 | External shift clock, asynchronous to clk |
| sdo_o | output | 1 | Serial data, MSB first |
| sdo_oe_o | output | 1 | Drive enable for the serial data pad |

## Verification
Two functions can act in the same system clock cycle: a word reload from a busy fall, and a shift strobe from a synchronized rising edge. The bench raises `sclk_i` and then lowers `busy_i` on the falling clock edge two cycles later, so that both strobes reach the register at the same rising edge. The preloaded word is all ones and the new word has a 0 MSB, so the output shows which of the two won. The next two shift clocks must show bits 14 and 13 of the new word, which confirms that the colliding edge was dropped rather than applied late.

// File: rtl/sport_pkg.sv
package sport_pkg;

   localparam int unsigned SPORT_DATA_W      = 16;
   localparam int unsigned SPORT_SYNC_STAGES = 2;

   typedef enum logic {
      SPORT_SHARED  = 1'b0,
      SPORT_CASCADE = 1'b1
   } sport_mode_e;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } sport_edge_e;

endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int unsigned LAST = STAGES - 1;

   initial begin
      assert (STAGES >= 2) else $error("sport_sync: STAGES must be at least 2");
      assert (WIDTH >= 1) else $error("sport_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= async_i;
         for (int s = 1; s < int'(STAGES); s++) begin
            stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign sync_o = stg_q[LAST];

endmodule

// File: rtl/sport_edge.sv
module sport_edge
   import sport_pkg::*;
#(
   parameter sport_edge_e POLARITY = EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic pulse_o
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i;
   end

   generate
      if (POLARITY == EDGE_RISE) begin : g_rise
         assign pulse_o = level_i & ~prev_q;
      end else begin : g_fall
         assign pulse_o = prev_q & ~level_i;
      end
   endgenerate

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o) else $error("edge pulse longer than one cycle"); // R9

endmodule

// File: rtl/sport_shreg.sv
module sport_shreg #(
   parameter int unsigned DATA_W    = 16,
   parameter bit          LOAD_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              shift_i,
   input  logic              fill_i,
   output logic              msb_o
);

   localparam int unsigned TOP = DATA_W - 1;

   initial begin
      assert (DATA_W >= 2) else $error("sport_shreg: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] sr_q;
   logic [DATA_W-1:0] sr_d;
   logic [DATA_W-1:0] shifted;

   assign shifted = {sr_q[TOP-1:0], fill_i};

   generate
      if (LOAD_WINS) begin : g_load_first
         always_comb begin
            if (load_i)       sr_d = data_i;
            else if (shift_i) sr_d = shifted;
            else              sr_d = sr_q;
         end

         AST_LOAD_OVER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            (load_i && shift_i) |=> (msb_o == $past(data_i[TOP])))
            else $error("shift beat a same-cycle load"); // R7

         AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
            load_i |=> (msb_o == $past(data_i[TOP])))
            else $error("loaded MSB not presented"); // R4
      end else begin : g_shift_first
         always_comb begin
            if (shift_i)     sr_d = shifted;
            else if (load_i) sr_d = data_i;
            else             sr_d = sr_q;
         end

         AST_SHIFT_OVER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (load_i && shift_i) |=> (msb_o == $past(sr_q[TOP-1])))
            else $error("load beat a same-cycle shift"); // R7
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_d;
   end

   assign msb_o = sr_q[TOP];

   AST_SHIFT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !load_i) |=> (msb_o == $past(sr_q[TOP-1])))
      else $error("shift did not advance"); // R3

   AST_FILL_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !load_i) |=> (sr_q[0] == $past(fill_i)))
      else $error("fill bit not taken at LSB"); // R5

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_i && !load_i) |=> $stable(sr_q))
      else $error("register moved without a strobe"); // R4

endmodule

// File: rtl/sport_drive.sv
module sport_drive (
   input  logic clk,
   input  logic rst_n,
   input  logic chain_i,
   input  logic dual_s_i,
   output logic oe_o
);

   logic oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= chain_i | ~dual_s_i;
   end

   assign oe_o = oe_q;

   AST_CHAIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      chain_i |=> oe_o) else $error("cascade mode released the line"); // R2

   AST_SHARED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!chain_i && dual_s_i) |=> !oe_o) else $error("disabled port drove the line"); // R1

endmodule

// File: rtl/chain_sport.sv
module chain_sport
   import sport_pkg::*;
#(
   parameter int unsigned DATA_W      = SPORT_DATA_W,
   parameter int unsigned SYNC_STAGES = SPORT_SYNC_STAGES,
   parameter bit          LOAD_WINS   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] result_i,
   input  logic              chain_i,
   input  logic              dual_i,
   input  logic              sclk_i,
   output logic              sdo_o,
   output logic              sdo_oe_o
);

   localparam int unsigned SYNC_W = 2;
   localparam int unsigned IDX_SCLK = 1;
   localparam int unsigned IDX_DUAL = 0;

   initial begin
      assert (DATA_W >= 2) else $error("chain_sport: DATA_W must be at least 2");
      assert (SYNC_STAGES >= 2) else $error("chain_sport: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_W-1:0] pins_s;
   logic              sclk_s;
   logic              dual_s;
   logic              shift_stb;
   logic              load_stb;
   logic              fill_bit;
   sport_mode_e       mode;

   // shift clock and dual pin share one synchronizer so cascade data lines up with its edge
   sport_sync #(
      .WIDTH  (SYNC_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({sclk_i, dual_i}),
      .sync_o  (pins_s)
   );

   assign sclk_s = pins_s[IDX_SCLK];
   assign dual_s = pins_s[IDX_DUAL];
   assign mode   = sport_mode_e'(chain_i);

   sport_edge #(.POLARITY(EDGE_RISE)) u_sclk_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (sclk_s),
      .pulse_o (shift_stb)
   );

   sport_edge #(.POLARITY(EDGE_FALL)) u_busy_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (busy_i),
      .pulse_o (load_stb)
   );

   assign fill_bit = (mode == SPORT_CASCADE) ? dual_s : 1'b0;

   sport_shreg #(
      .DATA_W    (DATA_W),
      .LOAD_WINS (LOAD_WINS)
   ) u_shreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_stb),
      .data_i  (result_i),
      .shift_i (shift_stb),
      .fill_i  (fill_bit),
      .msb_o   (sdo_o)
   );

   sport_drive u_drive (
      .clk      (clk),
      .rst_n    (rst_n),
      .chain_i  (chain_i),
      .dual_s_i (dual_s),
      .oe_o     (sdo_oe_o)
   );

   AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_stb && !load_stb && !chain_i) |-> !fill_bit)
      else $error("shared-line mode shifted in a one"); // R6

endmodule

// File: tb/chain_sport_bench.sv
`timescale 1ns/1ps
module chain_sport_bench;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         busy_i = 1'b0;
   logic [W-1:0] result_i = '0;
   logic         chain_i = 1'b0;
   logic         dual_i = 1'b1;
   logic         sclk_i = 1'b0;
   logic         sdo_o;
   logic         sdo_oe_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   typedef struct {
      bit    is_oe;
      logic  exp;
      string tag;
   } item_t;

   item_t exp_q[$];
   event  chk_ev;

   always #4 clk = ~clk;

   chain_sport u_chain_sport (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy_i   (busy_i),
      .result_i (result_i),
      .chain_i  (chain_i),
      .dual_i   (dual_i),
      .sclk_i   (sclk_i),
      .sdo_o    (sdo_o),
      .sdo_oe_o (sdo_oe_o)
   );

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         @(chk_ev);
         while (exp_q.size() > 0) begin
            item_t it;
            logic  act;
            it  = exp_q.pop_front();
            act = it.is_oe ? sdo_oe_o : sdo_o;
            n_tests++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: %s actual=%b expected=%b", it.tag,
                        it.is_oe ? "sdo_oe_o" : "sdo_o", act, it.exp);
            end
         end
      end
   end

   task automatic expect_bit(input bit is_oe, input logic e, input string tag);
      item_t it;
      it.is_oe = is_oe;
      it.exp   = e;
      it.tag   = tag;
      exp_q.push_back(it);
      -> chk_ev;
      #1;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load_word(input logic [W-1:0] w);
      result_i = w;
      busy_i   = 1'b1;
      wait_cyc(3);
      busy_i   = 1'b0;
      wait_cyc(2);
   endtask

   // one shift clock; checks the bit after the rising edge and that the falling edge holds it
   task automatic pulse(input logic din, input logic e, input string tag);
      sclk_i = 1'b1;
      if (chain_i) dual_i = din;
      wait_cyc(4);
      expect_bit(1'b0, e, tag);
      sclk_i = 1'b0;
      wait_cyc(4);
      expect_bit(1'b0, e, {tag, " fall edge R3"});
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] own;
      logic [W-1:0] up;
      wait_cyc(3);
      // R8 reset state
      expect_bit(1'b0, 1'b0, "R8 reset sdo");
      expect_bit(1'b1, 1'b0, "R8 reset oe");
      rst_n = 1'b1;
      wait_cyc(4);
      expect_bit(1'b1, 1'b0, "R1 dual high releases");

      dual_i = 1'b0;
      wait_cyc(4);
      expect_bit(1'b1, 1'b1, "R1 dual low drives");

      // R4 load and MSB before any shift clock
      own = 16'hA5C3;
      load_word(own);
      expect_bit(1'b0, own[15], "R4 MSB after busy fall");
      result_i = 16'h0000;
      wait_cyc(3);
      expect_bit(1'b0, own[15], "R4 result change ignored");

      // R3 MSB-first readout, R9 latency
      for (int i = 0; i < 15; i++) pulse(1'b0, own[14-i], "R3 R9 shared readout");
      // R6 zero fill
      for (int i = 0; i < 3; i++) pulse(1'b0, 1'b0, "R6 zero fill");

      dual_i = 1'b1;
      wait_cyc(4);
      expect_bit(1'b1, 1'b0, "R1 release again");

      // cascade
      chain_i = 1'b1;
      wait_cyc(4);
      expect_bit(1'b1, 1'b1, "R2 cascade drives with dual high");
      own = 16'h1234;
      up  = 16'hBEEF;
      load_word(own);
      expect_bit(1'b0, own[15], "R4 cascade load MSB");
      for (int i = 0; i < 31; i++) begin
         logic d;
         logic e;
         d = (i < 16) ? up[15-i] : 1'b0;
         e = (i < 15) ? own[14-i] : up[15-(i-15)];
         pulse(d, e, (i < 15) ? "R5 own word first" : "R5 upstream word follows");
      end
      dual_i = 1'b0;
      wait_cyc(4);
      expect_bit(1'b1, 1'b1, "R2 cascade drives with dual low");

      // R7 collision of load and shift strobe
      chain_i = 1'b0;
      dual_i  = 1'b0;
      load_word(16'hFFFF);
      expect_bit(1'b0, 1'b1, "R7 preload");
      result_i = 16'h4001;
      busy_i   = 1'b1;
      wait_cyc(3);
      sclk_i = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      busy_i = 1'b0;
      wait_cyc(3);
      expect_bit(1'b0, 1'b0, "R7 load wins over shift");
      sclk_i = 1'b0;
      wait_cyc(4);
      pulse(1'b0, 1'b1, "R7 next bit is bit14");
      pulse(1'b0, 1'b0, "R7 then bit13");

      wait_cyc(2);
      -> chk_ev;
      #1;
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule